// File: doc/BRIEF.md
# DRAM CAS-before-RAS Refresh and Power-up Sequencer

This block keeps an asynchronous DRAM array refreshed by issuing CAS-before-RAS (CBR) cycles. In these cycles the memory takes the row to refresh from its own internal counter, so the sequencer never drives an address. After reset it waits out a fixed power-up pause. It then runs a fixed number of CBR warm-up cycles on its own. Only after that does it raise `init_done_o` to let the access controller start.

In normal operation an interval timer spaces the refreshes so that the whole row count is covered once per retention period. A parameter picks either the standard or the low-power retention period. Each timer tick adds one to a saturating pending counter. The sequencer asks the access controller for the pins with `refresh_req_o`, and starts a cycle on the clock after it sees `refresh_grant_i` together with its own request. While the cycle runs, `drive_en_o` is high and the sequencer owns RAS (all banks at once), CAS and WE. When the pending count reaches its ceiling, `force_close_o` tells the access controller to close its open row at the next opportunity. This lets a long page burst defer refreshes only up to that limit.

All analogue timing limits are given in nanoseconds and converted to whole clock cycles using the clock period parameter.

Top module: `dram_refresh_seq`

## Requirements
- R1: From reset until the power-up pause of ceil(PAUSE_NS/CLK_PERIOD_NS) cycles has elapsed, `drive_en_o`, `refresh_req_o`, `force_close_o` and `init_done_o` stay low, and every RAS line, CAS and WE stay high.
- R2: After the pause, exactly WARMUP_CYCLES CBR cycles (8 by default) are issued without any grant. `init_done_o` rises on the clock after the last of them ends, and stays high until the next reset.
- R3: In every CBR cycle, CAS is low for ceil(10 ns) cycles before RAS falls. It stays low for ceil(10 ns) cycles starting with the cycle in which RAS falls, and then returns high.
- R4: RAS stays low for max(ceil(60 ns), CAS hold) cycles. It then stays high, with CAS also high, for max(ceil(40 ns), ceil(10 ns), RC − RAS) cycles, where RC = ceil(110 ns). A new cycle can begin only after that.
- R5: WE is high in every cycle, including throughout every CBR cycle.
- R6: All RAS_BANKS RAS outputs carry the same value in every cycle.
- R7: Once `init_done_o` is high, a refresh becomes due every floor(floor(RET/1024)/CLK_PERIOD_NS) cycles. RET is RETENTION_LP_NS when LOW_POWER=1 and RETENTION_STD_NS otherwise. The first refresh is due that many cycles after `init_done_o` rises.
- R8: The count of due refreshes goes up by one on each interval and saturates at MAX_PENDING (8). `refresh_req_o` is high exactly when `init_done_o` is high, the count is non-zero and no CBR cycle is running.
- R9: When `refresh_req_o` and `refresh_grant_i` are both high at a clock edge, `drive_en_o` rises after that edge, CAS falls with it, and the count drops by one. A grant while `refresh_req_o` is low has no effect.
- R10: `force_close_o` is high exactly when the count of due refreshes equals MAX_PENDING.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| refresh_grant_i | input | 1 | Access controller hands the DRAM pins over for one refresh |
| refresh_req_o | output | 1 | A refresh is due and the sequencer is idle |
| force_close_o | output | 1 | Pending refreshes at their ceiling; close the open row |
| init_done_o | output | 1 | Power-up pause and warm-up finished; normal access allowed |
| drive_en_o | output | 1 | Sequencer owns RAS, CAS and WE this cycle |
| ras_n_o | output | RAS_BANKS | Row strobes, active low, one per bank, all moved together |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |

## Verification
The bench builds the block with a 10 ns clock and LOW_POWER=1. It shrinks the low-power retention so that a refresh falls due every 50 cycles, and sets the standard retention to a different value so that a wrong selection changes the spacing. It also shortens the power-up pause to 300 cycles. With these values, the full warm-up, saturation of the pending count with the grant held off, the drain, and an irregular grant pattern all fit in a few thousand cycles. The cycle-timing parameters stay at their nominal values, which gives a 1-cycle CAS setup and hold, a 6-cycle RAS low and a 5-cycle precharge.

// File: rtl/dram_ref_pkg.sv
// Shared types and helpers for the DRAM refresh sequencer.
// Assumes all times are integer nanoseconds.
package dram_ref_pkg;

    typedef enum logic [1:0] {
        ST_PAUSE = 2'd0,
        ST_WARM  = 2'd1,
        ST_RUN   = 2'd2
    } seq_state_e;

    // Nanoseconds to whole clock cycles, rounded up, never below one.
    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ref_interval_timer.sv
// Interval timer: pulses tick_o once every INTERVAL_CYC cycles while en_i is
// high and restarts from zero whenever en_i is low.
// Assumes INTERVAL_CYC >= 2.
module ref_interval_timer #(
    parameter int INTERVAL_CYC = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int TW = (INTERVAL_CYC > 2) ? $clog2(INTERVAL_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

    logic [TW-1:0] cnt;

    assign tick_o = en_i && (cnt == LAST);

    // Count cycles within the current interval.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt <= '0;
        end else if (tick_o) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R7

endmodule

// File: rtl/ref_pending_ctr.sv
// Saturating count of refreshes that are due but not yet issued.
// Assumes dec_i is only raised while the count is non-zero.
module ref_pending_ctr #(
    parameter int MAX_PENDING = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc_i,
    input  logic dec_i,
    output logic nonzero_o,
    output logic full_o
);
    localparam int CW = $clog2(MAX_PENDING + 1);
    localparam logic [CW-1:0] MAXV = CW'(MAX_PENDING);

    logic [CW-1:0] cnt;

    assign nonzero_o = (cnt != '0);
    assign full_o    = (cnt == MAXV);

    // Add on interval, subtract on issue, hold when both or at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (inc_i && !dec_i && !full_o) begin
            cnt <= cnt + 1'b1;
        end else if (dec_i && !inc_i) begin
            cnt <= cnt - 1'b1;
        end
    end

    AST_PENDING_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= MAXV); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> (cnt != '0)); // R9

endmodule

// File: rtl/cbr_cycle_gen.sv
// Generates one CAS-before-RAS refresh cycle per start pulse.
// Position 0..CSR-1: CAS low only. Then RAS low for RAS_CYC cycles, with CAS
// held low for the first CHR_CYC of them. Then PRE_CYC cycles of precharge.
// Assumes CHR_CYC <= RAS_CYC and that start_i only arrives while idle.
module cbr_cycle_gen #(
    parameter int CSR_CYC   = 1,
    parameter int CHR_CYC   = 1,
    parameter int RAS_CYC   = 6,
    parameter int PRE_CYC   = 5,
    parameter int RAS_BANKS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    output logic                 busy_o,
    output logic [RAS_BANKS-1:0] ras_n_o,
    output logic                 cas_n_o,
    output logic                 we_n_o
);
    localparam int TOTAL = CSR_CYC + RAS_CYC + PRE_CYC;
    localparam int PW    = $clog2(TOTAL);
    localparam logic [PW-1:0] P_LAST    = PW'(TOTAL - 1);
    localparam logic [PW-1:0] P_RAS_ON  = PW'(CSR_CYC);
    localparam logic [PW-1:0] P_RAS_OFF = PW'(CSR_CYC + RAS_CYC);
    localparam logic [PW-1:0] P_CAS_OFF = PW'(CSR_CYC + CHR_CYC);

    logic          busy;
    logic [PW-1:0] pos;
    logic          ras_low;
    logic          cas_low;

    // Step through the positions of one refresh cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            pos  <= '0;
        end else if (start_i) begin
            busy <= 1'b1;
            pos  <= '0;
        end else if (busy) begin
            if (pos == P_LAST) begin
                busy <= 1'b0;
                pos  <= '0;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

    assign busy_o  = busy;
    assign cas_low = busy && (pos < P_CAS_OFF);
    assign ras_low = busy && (pos >= P_RAS_ON) && (pos < P_RAS_OFF);
    assign cas_n_o = ~cas_low;
    assign we_n_o  = 1'b1;

    // One row strobe per bank, all switched from the same phase.
    for (genvar b = 0; b < RAS_BANKS; b++) begin : g_bank
        assign ras_n_o[b] = ~ras_low;
    end

    // Run lengths of RAS low and high, used only by the checks below.
    logic [7:0] lo_len, hi_len;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_len <= '0;
            hi_len <= '0;
        end else if (!ras_n_o[0]) begin
            lo_len <= (lo_len == 8'hFF) ? lo_len : lo_len + 1'b1;
            hi_len <= '0;
        end else begin
            hi_len <= (hi_len == 8'hFF) ? hi_len : hi_len + 1'b1;
            lo_len <= '0;
        end
    end

    AST_CAS_BEFORE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o[0]) |-> (!cas_n_o && $past(!cas_n_o))); // R3
    AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n_o[0]) |-> (lo_len >= 8'(RAS_CYC))); // R4
    AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o[0]) |-> (hi_len >= 8'(PRE_CYC))); // R4
    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy); // R9

endmodule

// File: rtl/dram_refresh_seq.sv
// Top of the CBR refresh sequencer. It waits out the power-up pause, runs the
// warm-up CBR cycles on its own, then issues paced refreshes through a
// request/grant handshake with the access controller.
// Assumes the access controller releases RAS/CAS/WE whenever drive_en_o is high.
module dram_refresh_seq #(
    parameter int CLK_PERIOD_NS    = 10,
    parameter int LOW_POWER        = 0,
    parameter int ROWS             = 1024,
    parameter int RETENTION_STD_NS = 16_000_000,
    parameter int RETENTION_LP_NS  = 128_000_000,
    parameter int PAUSE_NS         = 200_000,
    parameter int WARMUP_CYCLES    = 8,
    parameter int MAX_PENDING      = 8,
    parameter int RAS_BANKS        = 2,
    parameter int T_CSR_NS         = 10,
    parameter int T_CHR_NS         = 10,
    parameter int T_RAS_NS         = 60,
    parameter int T_RP_NS          = 40,
    parameter int T_RC_NS          = 110,
    parameter int T_RPC_NS         = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 refresh_grant_i,
    output logic                 refresh_req_o,
    output logic                 force_close_o,
    output logic                 init_done_o,
    output logic                 drive_en_o,
    output logic [RAS_BANKS-1:0] ras_n_o,
    output logic                 cas_n_o,
    output logic                 we_n_o
);
    import dram_ref_pkg::*;

    localparam int CSR_CYC  = ns_to_cyc(T_CSR_NS, CLK_PERIOD_NS);
    localparam int CHR_CYC  = ns_to_cyc(T_CHR_NS, CLK_PERIOD_NS);
    localparam int RAS_CYC  = max2(ns_to_cyc(T_RAS_NS, CLK_PERIOD_NS), CHR_CYC);
    localparam int RC_CYC   = ns_to_cyc(T_RC_NS, CLK_PERIOD_NS);
    localparam int PRE_CYC  = max2(max2(ns_to_cyc(T_RP_NS, CLK_PERIOD_NS),
                                        ns_to_cyc(T_RPC_NS, CLK_PERIOD_NS)),
                                   RC_CYC - RAS_CYC);
    localparam int RET_NS   = (LOW_POWER != 0) ? RETENTION_LP_NS : RETENTION_STD_NS;
    localparam int INTERVAL_CYC = (RET_NS / ROWS) / CLK_PERIOD_NS;
    localparam int PAUSE_CYC    = ns_to_cyc(PAUSE_NS, CLK_PERIOD_NS);
    localparam int PCW = $clog2(PAUSE_CYC + 1);
    localparam int WCW = $clog2(WARMUP_CYCLES + 1);
    localparam logic [PCW-1:0] PAUSE_LAST = PCW'(PAUSE_CYC - 1);
    localparam logic [WCW-1:0] WARM_ALL   = WCW'(WARMUP_CYCLES);

    seq_state_e     state;
    logic [PCW-1:0] pause_cnt;
    logic [WCW-1:0] warm_cnt;
    logic           busy;
    logic           tick;
    logic           pend_nz;
    logic           pend_full;
    logic           warm_start;
    logic           run_start;
    logic           start;
    logic           running;

    assign running    = (state == ST_RUN);
    assign warm_start = (state == ST_WARM) && !busy && (warm_cnt != WARM_ALL);
    assign run_start  = refresh_req_o && refresh_grant_i;
    assign start      = warm_start || run_start;

    assign refresh_req_o = running && pend_nz && !busy;
    assign force_close_o = pend_full;
    assign init_done_o   = running;
    assign drive_en_o    = busy;

    // Power-up sequence: pause, warm-up cycles, then normal running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_PAUSE;
            pause_cnt <= '0;
            warm_cnt  <= '0;
        end else begin
            case (state)
                ST_PAUSE: begin
                    if (pause_cnt == PAUSE_LAST) begin
                        state <= ST_WARM;
                    end else begin
                        pause_cnt <= pause_cnt + 1'b1;
                    end
                end
                ST_WARM: begin
                    if (warm_start) begin
                        warm_cnt <= warm_cnt + 1'b1;
                    end else if (!busy && (warm_cnt == WARM_ALL)) begin
                        state <= ST_RUN;
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    ref_interval_timer #(
        .INTERVAL_CYC (INTERVAL_CYC)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (running),
        .tick_o (tick)
    );

    ref_pending_ctr #(
        .MAX_PENDING (MAX_PENDING)
    ) i_pending (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_i     (tick),
        .dec_i     (run_start),
        .nonzero_o (pend_nz),
        .full_o    (pend_full)
    );

    cbr_cycle_gen #(
        .CSR_CYC   (CSR_CYC),
        .CHR_CYC   (CHR_CYC),
        .RAS_CYC   (RAS_CYC),
        .PRE_CYC   (PRE_CYC),
        .RAS_BANKS (RAS_BANKS)
    ) i_cycle (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .busy_o  (busy),
        .ras_n_o (ras_n_o),
        .cas_n_o (cas_n_o),
        .we_n_o  (we_n_o)
    );

    AST_QUIET_IN_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAUSE) |-> (!drive_en_o && cas_n_o)); // R1
    AST_WARMUP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done_o) |-> (warm_cnt == WARM_ALL)); // R2
    AST_GRANT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_req_o && refresh_grant_i) |=> (drive_en_o && !cas_n_o)); // R9
    AST_URGENT_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        force_close_o |-> (refresh_req_o || drive_en_o)); // R10

endmodule

// File: tb/test_dram_refresh_seq.sv
// Self-checking bench: a behavioural reference model is stepped on every clock
// and compared with the outputs at the falling edge.
module test_dram_refresh_seq;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;
    localparam int BANKS      = 2;
    localparam int RET_LP     = 512_000;   // 500 ns per row -> 50 cycles
    localparam int RET_STD    = 204_800;   // 200 ns per row -> 20 cycles
    localparam int PAUSE_NS   = 3_000;
    localparam int WARM       = 8;
    localparam int MAXP       = 8;
    localparam int WATCHDOG   = 20_000;

    // Expected cycle counts from the requirements.
    localparam int E_CSR   = (10 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int E_CHR   = (10 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int E_RAS   = (60 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int E_RC    = (110 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int E_RP0   = (40 + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int E_PRE   = (E_RC - E_RAS > E_RP0) ? E_RC - E_RAS : E_RP0;
    localparam int E_TOT   = E_CSR + E_RAS + E_PRE;
    localparam int E_INT   = (RET_LP / 1024) / CLK_PERIOD;
    localparam int E_PAUSE = (PAUSE_NS + CLK_PERIOD - 1) / CLK_PERIOD;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             grant = 1'b0;
    logic             req, force_close, init_done, drive_en, cas_n, we_n;
    logic [BANKS-1:0] ras_n;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #(HALF) clk = ~clk;

    dram_refresh_seq #(
        .CLK_PERIOD_NS    (CLK_PERIOD),
        .LOW_POWER        (1),
        .RETENTION_STD_NS (RET_STD),
        .RETENTION_LP_NS  (RET_LP),
        .PAUSE_NS         (PAUSE_NS),
        .WARMUP_CYCLES    (WARM),
        .MAX_PENDING      (MAXP),
        .RAS_BANKS        (BANKS)
    ) i_dram_refresh_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .refresh_grant_i (grant),
        .refresh_req_o   (req),
        .force_close_o   (force_close),
        .init_done_o     (init_done),
        .drive_en_o      (drive_en),
        .ras_n_o         (ras_n),
        .cas_n_o         (cas_n),
        .we_n_o          (we_n)
    );

    // Reference model state.
    int m_phase;     // 0 pause, 1 warm-up, 2 running
    int m_pause, m_warm, m_pos, m_pend, m_tmr;
    bit m_busy, m_valid;

    // Advance the reference model by one clock.
    always @(posedge clk) begin
        bit run, mreq, st, tk, nbusy;
        int npos;
        if (!rst_n) begin
            m_phase = 0; m_pause = 0; m_warm = 0; m_pos = 0;
            m_pend = 0; m_tmr = 0; m_busy = 0; m_valid = 1;
        end else if (m_valid) begin
            run  = (m_phase == 2);
            mreq = run && m_pend > 0 && !m_busy;
            st   = (m_phase == 1 && !m_busy && m_warm < WARM) || (mreq && grant);
            tk   = run && (m_tmr == E_INT - 1);
            nbusy = m_busy; npos = m_pos;
            if (st) begin nbusy = 1; npos = 0; end
            else if (m_busy) begin
                if (m_pos == E_TOT - 1) begin nbusy = 0; npos = 0; end
                else npos = m_pos + 1;
            end
            if (m_phase == 0) begin
                if (m_pause == E_PAUSE - 1) m_phase = 1; else m_pause++;
            end else if (m_phase == 1) begin
                if (st) m_warm++;
                else if (!m_busy && m_warm == WARM) m_phase = 2;
            end
            m_tmr = run ? (tk ? 0 : m_tmr + 1) : 0;
            if (tk && !(mreq && grant) && m_pend < MAXP) m_pend++;
            else if ((mreq && grant) && !tk) m_pend--;
            m_busy = nbusy; m_pos = npos;
        end
    end

    task automatic chk(input string rq, input string what, input int act, input int exp);
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", rq, what, act, exp, $time);
        end
    endtask

    // Per-clock comparison plus pin statistics.
    int  ras_falls_pre_init = 0;
    int  first_cas_cyc = -1;
    int  cyc_since_rst = 0;
    int  falls_while_blocked = 0;
    bit  blocked = 0;
    bit  seen_force = 0;
    logic prev_ras = 1'b1;

    always @(negedge clk) begin
        if (m_valid && !done) begin
            bit e_cas, e_ras;
            vectors++;
            e_cas = !(m_busy && m_pos < E_CSR + E_CHR);
            e_ras = !(m_busy && m_pos >= E_CSR && m_pos < E_CSR + E_RAS);
            chk("R3", "cas_n", cas_n, e_cas);
            chk("R4", "ras_n[0]", ras_n[0], e_ras);
            chk("R6", "ras_n[1]", ras_n[1], ras_n[0]);
            chk("R5", "we_n", we_n, 1);
            chk("R9", "drive_en", drive_en, m_busy);
            chk("R2", "init_done", init_done, m_phase == 2);
            chk("R8", "refresh_req", req, m_phase == 2 && m_pend > 0 && !m_busy);
            chk("R10", "force_close", force_close, m_pend == MAXP);
            if (rst_n) begin
                cyc_since_rst++;
                if (!cas_n && first_cas_cyc < 0) first_cas_cyc = cyc_since_rst;
                if (prev_ras && !ras_n[0] && !init_done) ras_falls_pre_init++;
                if (prev_ras && !ras_n[0] && blocked) falls_while_blocked++;
                if (force_close) seen_force = 1;
            end
            prev_ras = ras_n[0];
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state after the first edge under reset.
        vectors++; chk("R1", "reset init_done", init_done, 0);
        vectors++; chk("R1", "reset ras_n", ras_n, {BANKS{1'b1}});
        rst_n = 1'b1;
        wait (init_done);
        vectors++; chk("R1", "cycles before first CAS >= pause", first_cas_cyc > E_PAUSE, 1);
        vectors++; chk("R2", "warm-up RAS falls", ras_falls_pre_init, WARM);
        // R8/R10/R9: hold the grant off long enough to saturate the count.
        @(negedge clk); blocked = 1;
        repeat (E_INT * (MAXP + 3)) @(negedge clk);
        vectors++; chk("R10", "force_close reached", seen_force, 1);
        vectors++; chk("R9", "no refresh without grant", falls_while_blocked, 0);
        blocked = 0;
        grant = 1'b1;
        repeat (E_TOT * (MAXP + 2) + 20) @(negedge clk);
        vectors++; chk("R10", "drained force_close", force_close, 0);
        // R7/R9: irregular grant pattern.
        for (int i = 0; i < 1500; i++) begin
            grant = ((i % 7) < 3) || ((i % 11) == 5);
            @(negedge clk);
        end
        grant = 1'b0;
        repeat (E_INT) @(negedge clk);
        // R1: synchronous reset mid-run returns to the quiet state.
        rst_n = 1'b0;
        @(negedge clk);
        vectors++; chk("R1", "re-reset init_done", init_done, 0);
        vectors++; chk("R1", "re-reset drive_en", drive_en, 0);
        finish_run();
    end

endmodule